// File: doc/BRIEF.md
# USB Device Address and Bus-Event Controller

This block holds the device-level state of a full-speed USB function. Software loads a new 7-bit function address through a small register port. The block keeps that value pending and reports a pending flag while it waits. It moves the value into the active address only when the packet engine signals that the current transfer has finished. Until then the previous address stays in use for token matching.

The block also handles bus-level events. A bus-reset detect pulse, or a reset that software forces through a control bit, runs one fixed clearing sequence. The sequence zeroes both addresses. It drives one-cycle flush and clear strobes to the endpoint FIFOs, the endpoint status registers and the endpoint index logic. It re-arms every interrupt enable except the suspend enable, and it raises the reset interrupt. Suspend detection is gated by an enable. A resume or a bus reset leaves the suspended state, and each event sets its own interrupt flag.

Register map, selected by `reg_addr`. Reads are combinational.
- 0: bit 7 is the update flag (read-only); bits 6..0 hold the pending address.
- 1: bit 0 enables suspend detection (read/write); bit 1 forces a reset when written 1 (reads 0); bit 2 is the reset-seen status (write 1 to clear); bit 3 shows the suspended state (read-only).
- 2: interrupt enables, with bit 0 for reset, bit 1 for suspend and bit 2 for resume; the reset value is 0x05.
- 3: interrupt flags, in the same bit order; writing 1 to a bit clears it.

Top module: `usb_devctl`

## Requirements
- R1: After `rst_n` the registers read as follows: offset 0 reads 0x00, offset 1 reads 0x00, offset 2 reads 0x05 and offset 3 reads 0x00. `dev_addr`, `irq`, `suspended` and all three strobes are 0.
- R2: A write to offset 0 stores bits 6..0 as the pending address and sets the update flag, so offset 0 reads 0x80 | address. `dev_addr` keeps its previous value until a commit.
- R3: A `xfer_done` pulse while the update flag is set copies the pending address to `dev_addr` and clears the update flag at the same clock edge.
- R4: A second write to offset 0 before the commit replaces the pending value and leaves the flag set. If a write and `xfer_done` arrive in the same cycle, `dev_addr` takes the previously pending value, and the newly written value stays pending with the flag set.
- R5: At the edge that samples `bus_rst_det`, the pending address, `dev_addr` and the update flag are cleared, and the reset-seen bit (offset 1 bit 2) becomes 1. The suspend-detect enable is kept. The reset-seen bit is cleared by writing 1 to it.
- R6: `fifo_flush`, `csr_clear` and `idx_clear` are high for exactly the one cycle after the cycle in which the reset event was sampled.
- R7: A reset event sets the reset and resume enables to 1 and leaves the suspend enable unchanged. It clears every flag and then sets the reset flag (offset 3 reads 0x01).
- R8: Writing 1 to offset 1 bit 1 runs the R5 to R7 sequence one cycle after the write. Bit 1 reads back as 0.
- R9: `susp_det` with the suspend-detect enable set makes `suspended` 1 and sets the suspend flag. `susp_det` with the enable clear has no effect.
- R10: `resume_det` while suspended clears `suspended` and sets the resume flag. `resume_det` when not suspended changes nothing. A reset event also clears `suspended`.
- R11: `irq` is 1 exactly when some flag and its enable are both 1. Writing 1 to a flag bit clears only that flag.
- R12: A bus reset in the same cycle as a register write wins: the address ends at 0x00 with no update pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xfer_done | input | 1 | Current control transfer has completed |
| bus_rst_det | input | 1 | Bus reset detected (pulse) |
| susp_det | input | 1 | Suspend signaling detected (pulse) |
| resume_det | input | 1 | Resume signaling detected (pulse) |
| dev_addr | output | 7 | Active function address used for matching |
| suspended | output | 1 | Device is in the suspended state |
| fifo_flush | output | 1 | Flush strobe to endpoint FIFOs |
| csr_clear | output | 1 | Clear strobe to endpoint status registers |
| idx_clear | output | 1 | Clear strobe to endpoint index register |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked by assertions on every cycle:
- the active address stays stable between commits;
- a commit copies the pending value;
- a reset event clears both addresses and the suspended state;
- the suspend enable survives a reset event;
- the strobes last only one cycle;
- a bus reset beats a register write.

Other behaviour shows only in the bench's directed scenarios, which read it back through the register port:
- the readable pending flag and the exact register encodings;
- the one-cycle lag of a software-forced reset;
- whether a flag is raised, depending on the suspend-detect enable and on whether the device is suspended;
- the gating of `irq` by individual enables.

// File: rtl/usb_devctl_pkg.sv
// Package: shared offsets, bit positions and defaults for the USB device
// controller. Assumes a 2-bit register offset and three interrupt sources.
package usb_devctl_pkg;

    localparam int FA_W  = 7;   // function address width
    localparam int RA_W  = 2;   // register offset width
    localparam int N_IRQ = 3;   // interrupt sources
    localparam int N_STB = 3;   // clear strobes

    typedef enum logic [RA_W-1:0] {
        OFF_ADDR = 2'd0,
        OFF_CTRL = 2'd1,
        OFF_IE   = 2'd2,
        OFF_FLAG = 2'd3
    } reg_off_e;

    // interrupt bit positions (shared by enable and flag registers)
    localparam int IRQ_RST  = 0;
    localparam int IRQ_SUSP = 1;
    localparam int IRQ_RES  = 2;

    localparam logic [N_IRQ-1:0] IE_DEFAULT = 3'b101;

    // control register bit positions
    localparam int CB_SUSP_EN   = 0;
    localparam int CB_FORCE     = 1;
    localparam int CB_RST_SEEN  = 2;
    localparam int CB_SUSPENDED = 3;

    // strobe positions
    localparam int STB_FIFO = 0;
    localparam int STB_CSR  = 1;
    localparam int STB_IDX  = 2;

endpackage

// File: rtl/usb_devctl_addr.sv
// Module: pending/active function address pair.
// A write loads the pending value and sets the update flag. A commit
// strobe moves pending into active while the flag is set. A reset event
// clears everything and takes priority over a write.
module usb_devctl_addr #(
    parameter int FA_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_evt,
    input  logic            wr_en,
    input  logic [FA_W-1:0] wr_val,
    input  logic            xfer_done,
    output logic [FA_W-1:0] pend_addr,
    output logic [FA_W-1:0] act_addr,
    output logic            upd_flag
);

    logic commit;
    assign commit = xfer_done && upd_flag;

    // Purpose: hold pending value, active value and update flag.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) begin
            pend_addr <= '0;
            act_addr  <= '0;
            upd_flag  <= 1'b0;
        end else begin
            if (commit) begin
                act_addr <= pend_addr;
            end
            if (wr_en) begin
                pend_addr <= wr_val;
                upd_flag  <= 1'b1;
            end else if (commit) begin
                upd_flag  <= 1'b0;
            end
        end
    end

    p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_evt && !xfer_done) |=> $stable(act_addr));

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_evt && xfer_done && upd_flag) |=> (act_addr == $past(pend_addr)));

    p_rewrite_keeps_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_evt && wr_en) |=> upd_flag);

    p_reset_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (act_addr == '0 && pend_addr == '0 && !upd_flag));

endmodule

// File: rtl/usb_devctl_evt.sv
// Module: bus-event sequencer.
// Merges the bus reset detect with a software-forced reset (delayed one
// cycle) into one reset event. Issues the clear strobes one cycle later
// and tracks the suspended state and the reset-seen status.
// Assumes the detect inputs are single-cycle pulses.
module usb_devctl_evt #(
    parameter int N_STB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_det,
    input  logic             force_wr,
    input  logic             ctrl_wr,
    input  logic             susp_en_wval,
    input  logic             seen_clr_wval,
    input  logic             susp_det,
    input  logic             resume_det,
    output logic             rst_evt,
    output logic [N_STB-1:0] strobes,
    output logic             susp_en,
    output logic             suspended,
    output logic             rst_seen,
    output logic             susp_evt,
    output logic             res_evt
);

    logic sw_rst_q;
    logic stb_q;

    // Purpose: delay the software reset request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_rst_q <= 1'b0;
        else        sw_rst_q <= force_wr;
    end

    assign rst_evt = bus_rst_det || sw_rst_q;

    // Purpose: register the clear strobe one cycle after the reset event.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= rst_evt;
    end

    for (genvar i = 0; i < N_STB; i++) begin : g_stb
        assign strobes[i] = stb_q;
    end

    // Purpose: suspend detection enable, kept across reset events.
    always_ff @(posedge clk) begin
        if (!rst_n)       susp_en <= 1'b0;
        else if (ctrl_wr) susp_en <= susp_en_wval;
    end

    assign res_evt  = !rst_evt && suspended && resume_det;
    assign susp_evt = !rst_evt && !suspended && susp_en && susp_det;

    // Purpose: track the suspended state.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) suspended <= 1'b0;
        else if (res_evt)      suspended <= 1'b0;
        else if (susp_evt)     suspended <= 1'b1;
    end

    // Purpose: reset-seen status, set by a reset event, cleared by write 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rst_seen <= 1'b0;
        else if (rst_evt)                  rst_seen <= 1'b1;
        else if (ctrl_wr && seen_clr_wval) rst_seen <= 1'b0;
    end

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && !rst_evt) |=> !stb_q);

    p_strobe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_q) |-> $past(rst_evt));

    p_force_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> rst_evt);

    p_no_susp_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !susp_en) |=> !suspended);

    p_exit_on_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (!suspended && rst_seen));

endmodule

// File: rtl/usb_devctl_irq.sv
// Module: interrupt enable and flag bank.
// Flags are set by event inputs and cleared by a write of 1. A reset
// event re-arms every enable except suspend, clears every flag and
// raises the reset flag.
module usb_devctl_irq
    import usb_devctl_pkg::*;
#(
    parameter int N = N_IRQ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rst_evt,
    input  logic         ie_wr,
    input  logic         flag_wr,
    input  logic [N-1:0] wval,
    input  logic [N-1:0] set_vec,
    output logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_src
        // Purpose: one enable bit; the suspend bit ignores reset events.
        always_ff @(posedge clk) begin
            if (!rst_n)                      ie[i] <= IE_DEFAULT[i];
            else if (rst_evt && i != IRQ_SUSP) ie[i] <= 1'b1;
            else if (!rst_evt && ie_wr)      ie[i] <= wval[i];
        end

        // Purpose: one flag bit, set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (rst_evt)  flags[i] <= (i == IRQ_RST);
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (flag_wr && wval[i]) flags[i] <= 1'b0;
        end
    end

    assign irq = |(ie & flags);

    p_ie_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (ie[IRQ_RST] && ie[IRQ_RES] && ie[IRQ_SUSP] == $past(ie[IRQ_SUSP])));

    p_flags_after_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (flags == N'(1 << IRQ_RST)));

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0 && !flag_wr && !rst_evt) |=> (flags != '0));

endmodule

// File: rtl/usb_devctl.sv
// Module: USB device address and bus-event controller (top).
// Decodes the register port and combines the address pair, the event
// sequencer and the interrupt bank. Reads are combinational.
module usb_devctl
    import usb_devctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] reg_addr,
    input  logic            reg_wr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            xfer_done,
    input  logic            bus_rst_det,
    input  logic            susp_det,
    input  logic            resume_det,
    output logic [FA_W-1:0] dev_addr,
    output logic            suspended,
    output logic            fifo_flush,
    output logic            csr_clear,
    output logic            idx_clear,
    output logic            irq
);

    reg_off_e        off;
    logic            wr_addr, wr_ctrl, wr_ie, wr_flag;
    logic            rst_evt, susp_en, rst_seen, susp_evt, res_evt;
    logic [FA_W-1:0] pend_addr;
    logic            upd_flag;
    logic [N_STB-1:0] strobes;
    logic [N_IRQ-1:0] ie, flags, set_vec;
    logic            unused_wbit;

    assign off     = reg_off_e'(reg_addr);
    assign wr_addr = reg_wr && off == OFF_ADDR;
    assign wr_ctrl = reg_wr && off == OFF_CTRL;
    assign wr_ie   = reg_wr && off == OFF_IE;
    assign wr_flag = reg_wr && off == OFF_FLAG;
    assign unused_wbit = reg_wdata[7];

    usb_devctl_addr #(.FA_W(FA_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_evt   (rst_evt),
        .wr_en     (wr_addr),
        .wr_val    (reg_wdata[FA_W-1:0]),
        .xfer_done (xfer_done),
        .pend_addr (pend_addr),
        .act_addr  (dev_addr),
        .upd_flag  (upd_flag)
    );

    usb_devctl_evt #(.N_STB(N_STB)) u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rst_det   (bus_rst_det),
        .force_wr      (wr_ctrl && reg_wdata[CB_FORCE]),
        .ctrl_wr       (wr_ctrl),
        .susp_en_wval  (reg_wdata[CB_SUSP_EN]),
        .seen_clr_wval (reg_wdata[CB_RST_SEEN]),
        .susp_det      (susp_det),
        .resume_det    (resume_det),
        .rst_evt       (rst_evt),
        .strobes       (strobes),
        .susp_en       (susp_en),
        .suspended     (suspended),
        .rst_seen      (rst_seen),
        .susp_evt      (susp_evt),
        .res_evt       (res_evt)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_SUSP] = susp_evt;
        set_vec[IRQ_RES]  = res_evt;
    end

    usb_devctl_irq #(.N(N_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_evt (rst_evt),
        .ie_wr   (wr_ie),
        .flag_wr (wr_flag),
        .wval    (reg_wdata[N_IRQ-1:0]),
        .set_vec (set_vec),
        .ie      (ie),
        .flags   (flags),
        .irq     (irq)
    );

    assign fifo_flush = strobes[STB_FIFO];
    assign csr_clear  = strobes[STB_CSR];
    assign idx_clear  = strobes[STB_IDX];

    // Purpose: register readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (off)
            OFF_ADDR: reg_rdata = {upd_flag, pend_addr};
            OFF_CTRL: begin
                reg_rdata[CB_SUSP_EN]   = susp_en;
                reg_rdata[CB_RST_SEEN]  = rst_seen;
                reg_rdata[CB_SUSPENDED] = suspended;
            end
            OFF_IE:   reg_rdata[N_IRQ-1:0] = ie;
            OFF_FLAG: reg_rdata[N_IRQ-1:0] = flags;
            default:  reg_rdata = '0;
        endcase
    end

    p_busrst_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_det && reg_wr) |=> (dev_addr == '0 && !upd_flag));

    p_strobes_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flush == csr_clear) && (csr_clear == idx_clear));

endmodule

// File: tb/usb_devctl_bench.sv
module usb_devctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       xfer_done = 1'b0;
    logic       bus_rst_det = 1'b0;
    logic       susp_det = 1'b0;
    logic       resume_det = 1'b0;
    logic [6:0] dev_addr;
    logic       suspended, fifo_flush, csr_clear, idx_clear, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    usb_devctl u_usb_devctl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .bus_rst_det(bus_rst_det), .susp_det(susp_det), .resume_det(resume_det),
        .dev_addr(dev_addr), .suspended(suspended), .fifo_flush(fifo_flush),
        .csr_clear(csr_clear), .idx_clear(idx_clear), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input int exp);
        logic [7:0] d;
        rd(a, d);
        check(tag, int'(d), exp);
    endtask

    task automatic pulse_xfer();
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic pulse_susp();
        susp_det = 1'b1; @(negedge clk); susp_det = 1'b0;
    endtask

    task automatic pulse_resume();
        resume_det = 1'b1; @(negedge clk); resume_det = 1'b0;
    endtask

    task automatic t_reset_values();
        chk_reg("R1 addr reg", 0, 8'h00);
        chk_reg("R1 ctrl reg", 1, 8'h00);
        chk_reg("R1 ie reg", 2, 8'h05);
        chk_reg("R1 flag reg", 3, 8'h00);
        check("R1 dev_addr", int'(dev_addr), 0);
        check("R1 outputs", int'({irq, suspended, fifo_flush, csr_clear, idx_clear}), 0);
    endtask

    task automatic t_commit();
        wr(0, 8'h2A);
        chk_reg("R2 pending+flag", 0, 8'hAA);
        check("R2 dev_addr held", int'(dev_addr), 0);
        @(negedge clk);
        check("R2 dev_addr still held", int'(dev_addr), 0);
        pulse_xfer();
        check("R3 committed", int'(dev_addr), 8'h2A);
        chk_reg("R3 flag cleared", 0, 8'h2A);
    endtask

    task automatic t_rewrite();
        wr(0, 8'h05);
        wr(0, 8'h06);
        chk_reg("R4 overwrite", 0, 8'h86);
        check("R4 old active", int'(dev_addr), 8'h2A);
        pulse_xfer();
        check("R4 commit latest", int'(dev_addr), 8'h06);
        // write and commit in the same cycle
        wr(0, 8'h11);
        reg_addr = 0; reg_wdata = 8'h22; reg_wr = 1'b1; xfer_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; xfer_done = 1'b0; reg_wdata = '0;
        check("R4 same-cycle active", int'(dev_addr), 8'h11);
        chk_reg("R4 same-cycle pending", 0, 8'hA2);
        pulse_xfer();
        check("R4 second commit", int'(dev_addr), 8'h22);
    endtask

    task automatic t_bus_reset();
        wr(2, 8'h02);
        wr(1, 8'h01);
        pulse_susp();
        check("R9 suspended", int'(suspended), 1);
        chk_reg("R9 susp flag", 3, 8'h02);
        check("R11 irq susp", int'(irq), 1);
        wr(0, 8'h33);
        bus_rst_det = 1'b1; @(negedge clk); bus_rst_det = 1'b0;
        check("R5 dev_addr", int'(dev_addr), 0);
        chk_reg("R5 addr reg", 0, 8'h00);
        chk_reg("R5 R10 ctrl", 1, 8'h05);
        check("R6 strobes on", int'({fifo_flush, csr_clear, idx_clear}), 7);
        chk_reg("R7 ie", 2, 8'h07);
        chk_reg("R7 flags", 3, 8'h01);
        @(negedge clk);
        check("R6 strobes off", int'({fifo_flush, csr_clear, idx_clear}), 0);
        wr(3, 8'h01);
        chk_reg("R11 w1c", 3, 8'h00);
        check("R11 irq low", int'(irq), 0);
        wr(1, 8'h05);
        chk_reg("R5 seen cleared", 1, 8'h01);
    endtask

    task automatic t_sw_reset();
        wr(0, 8'h44);
        pulse_xfer();
        wr(2, 8'h00);
        wr(1, 8'h03);
        check("R8 not yet", int'(dev_addr), 8'h44);
        check("R8 no strobe yet", int'(fifo_flush), 0);
        @(negedge clk);
        check("R8 dev_addr", int'(dev_addr), 0);
        check("R8 strobes", int'({fifo_flush, csr_clear, idx_clear}), 7);
        chk_reg("R8 R7 ie", 2, 8'h05);
        chk_reg("R8 flags", 3, 8'h01);
        chk_reg("R8 ctrl", 1, 8'h05);
        @(negedge clk);
        check("R6 sw strobe off", int'(fifo_flush), 0);
    endtask

    task automatic t_suspend();
        wr(1, 8'h04);
        wr(3, 8'h07);
        chk_reg("R9 ctrl clear", 1, 8'h00);
        pulse_susp();
        check("R9 disabled ignore", int'(suspended), 0);
        chk_reg("R9 no flag", 3, 8'h00);
        wr(1, 8'h01);
        pulse_susp();
        check("R9 enter", int'(suspended), 1);
        check("R11 susp gated", int'(irq), 0);
        pulse_resume();
        check("R10 leave", int'(suspended), 0);
        chk_reg("R10 resume flag", 3, 8'h06);
        check("R11 irq resume", int'(irq), 1);
        wr(3, 8'h04);
        chk_reg("R11 partial clear", 3, 8'h02);
        pulse_resume();
        chk_reg("R10 resume ignored", 3, 8'h02);
        check("R10 stays awake", int'(suspended), 0);
    endtask

    task automatic t_collision();
        wr(0, 8'h12);
        reg_addr = 0; reg_wdata = 8'h55; reg_wr = 1'b1; bus_rst_det = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; bus_rst_det = 1'b0; reg_wdata = '0;
        chk_reg("R12 addr reg", 0, 8'h00);
        check("R12 dev_addr", int'(dev_addr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_commit();
        t_rewrite();
        t_bus_reset();
        t_sw_reset();
        t_suspend();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule